// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Array

This block is a single output stage of a programmable sum-of-products logic device. It receives the OR of its product terms (the sum term) and an enable product term. It also receives two terms shared by every cell: an immediate clear and a clock-synchronous set. A two-bit configuration word selects the mode. In one mode the sum term passes through a D flip-flop. In the other mode it goes straight to the pin. The pin level can be inverted in either mode. A feedback signal goes back into the array. In registered mode it carries the stored bit. In combinational mode it carries whatever level is present on the pin.

The pin is modelled as a separate data output, an enable output and a returning pin value, so no bidirectional net is needed. A test strobe can force the flip-flop to the value seen on the pin. A secure flag blocks this strobe. A synchronous power-up reset puts the stored bit at LOW before operation starts.

Top module: `sop_out_cell`

## Requirements
- R1: Configuration bit 1 selects the mode (0 = registered, 1 = combinational). Configuration bit 0 selects the polarity (0 = pin inverted, active-low; 1 = pin true, active-high). An all-zero word therefore gives a registered, active-low cell.
- R2: In registered mode the stored bit takes `sum_in` on each rising clock edge. `pin_out` shows the stored bit, inverted when the cell is active-low.
- R3: In combinational mode `pin_out` follows `sum_in` within the same cycle, with no clock edge needed. It is inverted when the cell is active-low.
- R4: `fb_out` carries the uninverted stored bit in registered mode and carries `pin_in` in combinational mode.
- R5: `pin_oe` follows `oe_term` in every mode. With the enable low, a combinational cell acts as an input: `pin_in` reaches `fb_out`.
- R6: When `set_term` is high at a rising edge, the stored bit becomes 1.
- R7: While `clr_term` is high, the stored bit is 0 at once, without a clock edge. The clear takes precedence over set and over preload.
- R8: When `pld_strobe` is high and `pld_secure` is low at a rising edge, the stored bit takes the raw `pin_in` level. This takes precedence over `set_term` and `sum_in`.
- R9: When `pld_secure` is high, `pld_strobe` has no effect, and the stored bit follows `set_term` or `sum_in` as usual.
- R10: `rst` high at a rising edge clears the stored bit to 0. A registered active-low cell then drives its pin to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stored bit updates on rising edge |
| rst | input | 1 | Synchronous power-up reset, active high |
| cfg | input | 2 | Bit 1 = mode, bit 0 = polarity |
| sum_in | input | 1 | OR of this cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| clr_term | input | 1 | Shared immediate clear of the stored bit |
| set_term | input | 1 | Shared synchronous set of the stored bit |
| pld_strobe | input | 1 | Test preload strobe |
| pld_secure | input | 1 | Security flag that blocks preload |
| pin_in | input | 1 | Level present on the pin |
| pin_out | output | 1 | Data driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the logic array |

## Verification
The clocked properties assume that `clr_term` is held high across each rising edge it is meant to affect and is released only between edges. This is why the capture, set and preload properties are disabled while the clear is active. They also assume that `cfg` changes only between edges, so that the mode seen at one edge matches what the polarity and feedback properties inspect. The stimulus follows these rules. Every input changes on the falling clock edge. The one exception is the clear, which is raised partway through a cycle to show that it acts at once, and it stays high through the following rising edge.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
  localparam int CFG_W    = 2;
  localparam int MODE_BIT = 1;
  localparam int POL_BIT  = 0;

  typedef enum logic {
    CELL_REG  = 1'b0,
    CELL_COMB = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/sop_cell_cfg_dec.sv
module sop_cell_cfg_dec
  import sop_cell_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output cell_mode_e       mode,
  output logic             pol_high
);
  // An unprogrammed bit reads 0: registered, active-low.
  always_comb begin
    mode     = cell_mode_e'(cfg[MODE_BIT]);
    pol_high = cfg[POL_BIT];
  end
endmodule

// File: rtl/sop_cell_store.sv
module sop_cell_store (
  input  logic clk,
  input  logic rst,
  input  logic clr_term,
  input  logic set_term,
  input  logic pld_strobe,
  input  logic pld_secure,
  input  logic pin_in,
  input  logic d_in,
  output logic q
);
  logic pld_go;

  assign pld_go = pld_strobe & ~pld_secure;

  // Clear is asynchronous and wins; then reset, preload, set, data.
  always_ff @(posedge clk or posedge clr_term) begin
    if (clr_term)    q <= 1'b0;
    else if (rst)    q <= 1'b0;
    else if (pld_go) q <= pin_in;
    else if (set_term) q <= 1'b1;
    else             q <= d_in;
  end
endmodule

// File: rtl/sop_cell_drive.sv
module sop_cell_drive
  import sop_cell_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       pol_high,
  input  logic       q,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);
  logic level;

  always_comb begin
    unique case (mode)
      CELL_REG: begin
        level  = q;
        fb_out = q;
      end
      CELL_COMB: begin
        level  = sum_in;
        fb_out = pin_in;
      end
      default: begin
        level  = q;
        fb_out = q;
      end
    endcase
    pin_out = pol_high ? level : ~level;
    pin_oe  = oe_term;
  end
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             sum_in,
  input  logic             oe_term,
  input  logic             clr_term,
  input  logic             set_term,
  input  logic             pld_strobe,
  input  logic             pld_secure,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);
  cell_mode_e mode;
  logic       pol_high;
  logic       store_q;

  sop_cell_cfg_dec u_dec (
    .cfg      (cfg),
    .mode     (mode),
    .pol_high (pol_high)
  );

  sop_cell_store u_store (
    .clk        (clk),
    .rst        (rst),
    .clr_term   (clr_term),
    .set_term   (set_term),
    .pld_strobe (pld_strobe),
    .pld_secure (pld_secure),
    .pin_in     (pin_in),
    .d_in       (sum_in),
    .q          (store_q)
  );

  sop_cell_drive u_drive (
    .mode     (mode),
    .pol_high (pol_high),
    .q        (store_q),
    .sum_in   (sum_in),
    .oe_term  (oe_term),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_out   (fb_out)
  );
endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg,
  input logic       sum_in,
  input logic       clr_term,
  input logic       set_term,
  input logic       pld_strobe,
  input logic       pld_secure,
  input logic       pin_in,
  input logic       pin_out,
  input logic       fb_out,
  input logic       store_q
);
  // R2, R9: plain capture when neither set nor an accepted preload is present
  a_r2_capture: assert property (@(posedge clk) disable iff (rst || clr_term)
    (!set_term && !(pld_strobe && !pld_secure)) |=> store_q == $past(sum_in));

  // R6: set loads a one unless a preload is accepted
  a_r6_set: assert property (@(posedge clk) disable iff (rst || clr_term)
    (set_term && !(pld_strobe && !pld_secure)) |=> store_q);

  // R7: clear holds the stored bit low
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr_term |-> !store_q);

  // R8: accepted preload takes the pin level
  a_r8_preload: assert property (@(posedge clk) disable iff (rst || clr_term)
    (pld_strobe && !pld_secure) |=> store_q == $past(pin_in));

  // R4: combinational feedback is the pin
  a_r4_comb_fb: assert property (@(posedge clk) disable iff (rst)
    cfg[1] |-> fb_out == pin_in);

  // R1, R2: registered pin versus feedback by polarity
  a_r1_reg_pol: assert property (@(posedge clk) disable iff (rst)
    !cfg[1] |-> (pin_out == (cfg[0] ? fb_out : !fb_out)));
endmodule

bind sop_out_cell sop_out_cell_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg        (cfg),
  .sum_in     (sum_in),
  .clr_term   (clr_term),
  .set_term   (set_term),
  .pld_strobe (pld_strobe),
  .pld_secure (pld_secure),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .fb_out     (fb_out),
  .store_q    (store_q)
);

// File: tb/test_sop_out_cell.sv
`timescale 1ns/1ps
module test_sop_out_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg = 2'b00;
  logic       sum_in = 1'b0, oe_term = 1'b0, clr_term = 1'b0, set_term = 1'b0;
  logic       pld_strobe = 1'b0, pld_secure = 1'b0, pin_in = 1'b0;
  logic       pin_out, pin_oe, fb_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sop_out_cell i_sop_out_cell (
    .clk, .rst, .cfg, .sum_in, .oe_term, .clr_term, .set_term,
    .pld_strobe, .pld_secure, .pin_in, .pin_out, .pin_oe, .fb_out
  );

  // vector: cfg[1:0] sum oe set pld sec pin | exp_out exp_oe exp_fb
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    11'b00_1_1_0_0_0_0_0_1_1, // R2 blank cell captures 1, pin inverted
    11'b01_0_1_0_0_0_0_0_1_0, // R2 active-high captures 0
    11'b01_1_1_0_0_0_0_1_1_1, // R2 captures 1
    11'b01_0_1_1_0_0_0_1_1_1, // R6 set over sum
    11'b00_0_1_1_0_0_0_0_1_1, // R6 set, active-low pin
    11'b01_1_1_0_1_0_0_0_1_0, // R8 preload over sum
    11'b01_0_1_1_1_0_0_0_1_0, // R8 preload over set
    11'b01_0_1_0_1_1_1_0_1_0, // R9 secure: sum wins
    11'b01_1_1_0_1_1_0_1_1_1, // R9 secure: sum wins
    11'b11_0_1_0_0_0_1_0_1_1, // R3 R4 comb high, fb from pin
    11'b11_1_0_0_0_0_0_1_0_0, // R5 enable low, pin fed back
    11'b10_1_0_0_0_0_1_0_0_1, // R5 comb active-low input use
    11'b10_0_1_0_0_0_0_1_1_0  // R3 comb active-low
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 R1: blank cell after reset: stored 0, pin 1
    check("R10 reset pin", pin_out, 1'b1);
    check("R10 reset fb", fb_out, 1'b0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cfg, sum_in, oe_term, set_term, pld_strobe, pld_secure, pin_in} = VEC[i][10:3];
      @(posedge clk);
      #1;
      check($sformatf("R1-vec%0d out", i), pin_out, VEC[i][2]);
      check($sformatf("R5 vec%0d oe", i), pin_oe, VEC[i][1]);
      check($sformatf("R4 vec%0d fb", i), fb_out, VEC[i][0]);
    end

    // R3: combinational path follows sum with no clock edge
    @(negedge clk);
    {set_term, pld_strobe, pld_secure} = 3'b000;
    cfg = 2'b11; sum_in = 1'b0; #0.5;
    check("R3 comb low", pin_out, 1'b0);
    sum_in = 1'b1; #0.5;
    check("R3 comb same cycle", pin_out, 1'b1);

    // R7: immediate clear
    cfg = 2'b01;
    @(posedge clk); #1;
    check("R7 stored 1 before clear", pin_out, 1'b1);
    @(negedge clk); #0.5;
    clr_term = 1'b1; #0.5;
    check("R7 clear without clock", pin_out, 1'b0);
    set_term = 1'b1; pld_strobe = 1'b1; pin_in = 1'b1;
    @(posedge clk); #1;
    check("R7 clear over set/preload", pin_out, 1'b0);
    @(negedge clk);
    clr_term = 1'b0; set_term = 1'b0; pld_strobe = 1'b0;

    // R10: synchronous reset acts only at an edge
    @(posedge clk); #1;
    check("R10 stored 1 before reset", fb_out, 1'b1);
    @(negedge clk) rst = 1'b1; #0.5;
    check("R10 reset waits for edge", fb_out, 1'b1);
    @(posedge clk); #1;
    check("R10 reset clears", fb_out, 1'b0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule